// File: doc/BRIEF.md
# SPI Flash Transaction Sequencer

This block is a SPI master that carries out one serial-flash transaction for each accepted request. A transaction opens with chip select going low. It then shifts out 1 to 5 command bytes. An optional data phase follows, which either sends bytes taken from a write stream or captures bytes into a read stream. Chip select is then released. The sequencer knows nothing about flash opcodes. The requester supplies the command bytes, the data byte count, the direction and a transaction class. The class picks which of three programmable deselect times must pass before chip select may fall again.

The request channel and both data channels use valid/ready handshakes.

- **Request channel:** `req_ready` is high only while the block is idle. A request waits, unaccepted, for as long as the block is busy.
- **Write stream:** the block raises `wr_ready` only when its shifter is free to take the next byte. If `wr_valid` is low at that point, the serial clock stays at its idle level and chip select stays low until a byte arrives.
- **Read stream:** a captured byte is held on `rd_data` with `rd_valid` high until `rd_ready` takes it. No further read byte is clocked while that byte is still waiting.

Top module: `spi_txn_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` equals `cfg_cpol`, and `busy`, `rd_valid` and `wr_ready` are 0, while `req_ready` is 1.
- R2: Command bytes go out most significant bit first. The first byte is `req_cmd[39:32]`, the next is `req_cmd[31:24]`, and so on for `req_cmd_len` bytes. MOSI changes only while SCLK is low and is stable across each rising edge.
- R3: Chip select stays low without a break from acceptance until the last data bit. A transaction gives exactly 8 × (command bytes + data bytes) rising SCLK edges.
- R4: In a write (`req_read` = 0), the data bytes are taken from the write stream in order after the command bytes and sent MSB first. A stall on `wr_valid` holds chip select low and pauses SCLK.
- R5: In a read (`req_read` = 1), each data byte is built from MISO sampled on the rising edges, MSB first. MISO during the command phase is discarded. `rd_data` and `rd_valid` hold until `rd_ready` takes the byte.
- R6: A data count of 0 produces a command-only transaction.
- R7: SCLK rests at `cfg_cpol` (0 gives mode 0, 1 gives mode 3). Each SCLK level lasts `cfg_div`+1 clock cycles, and each unstalled byte after the first one adds one clock cycle. An unstalled write keeps chip select low for exactly (bytes) × (16 × (`cfg_div`+1) + 1) cycles.
- R8: With T the deselect time of the finished transaction's class, chip select stays high for at least max(T,1)+1 cycles, and for exactly that many when the next request is already waiting. The class encoding is: `req_class` 1 is read (`cfg_desel_rd`), 2 is erase/program/write (`cfg_desel_pgm`), and 0 or 3 is any other (`cfg_desel_oth`). `busy` is high from acceptance until the deselect time ends.
- R9: `spi_hold_n` is 1 whenever `spi_cs_n` is 0.
- R10: `req_ready` is 0 while `busy` is 1, so a request is never accepted during a transaction or its deselect time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_cpol | input | 1 | SCLK idle level (0 gives mode 0, 1 gives mode 3) |
| cfg_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| cfg_desel_rd | input | DSL_W | Deselect cycles after a read-class transaction |
| cfg_desel_pgm | input | DSL_W | Deselect cycles after an erase/program/write-class transaction |
| cfg_desel_oth | input | DSL_W | Deselect cycles after any other transaction |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (idle) |
| req_cmd | input | 8*CMD_MAX | Command bytes, first byte in the top octet |
| req_cmd_len | input | CLEN_W | Command byte count, 1 to CMD_MAX |
| req_data_len | input | LEN_W | Data byte count, may be 0 |
| req_read | input | 1 | 1 gives a read data phase, 0 gives a write data phase |
| req_class | input | 2 | Deselect class |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Transaction or deselect time in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_hold_n | output | 1 | Hold, driven inactive (1) while selected |
| spi_miso | input | 1 | Serial data in |

## Verification
- **Start of a transaction:** chip select falls on the edge that accepts a request. The first SCLK low phase begins one cycle later, and each bit then takes 2 × (`cfg_div`+1) cycles. The bench samples serial traffic on SCLK rising edges and sets MISO on the clock's falling edge.
- **End of a transaction and the deselect gap:** chip select rises on the same edge as the last falling-to-idle step. It then stays high for max(T,1)+1 cycles. The bench counts chip-select low and high cycles on falling clock edges and compares them with the cycle counts in R7 and R8.
- **Handshakes:** these are sampled one half cycle before the edge that completes them. Every byte and count comparison is made only after chip select has risen.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_READ  = 2'd1,
    CLS_PROG  = 2'd2,
    CLS_MISC  = 2'd3
  } txn_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
// One byte over SPI: MOSI changes as SCLK goes low, MISO is taken as it goes high.
module spi_byte_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             active_o,
  output logic             done_o,
  output logic [7:0]       rx_byte_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  logic             active_q;
  logic             half_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] cnt_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;
  logic             tick;

  assign tick   = active_q && (cnt_q == cfg_div);
  assign done_o = tick && half_q && (bit_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      bit_q    <= 3'd0;
      cnt_q    <= '0;
      sh_q     <= 8'h00;
      rx_q     <= 8'h00;
    end else if (start && !active_q) begin
      active_q <= 1'b1;
      half_q   <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= 3'd7;
      sh_q     <= tx_byte;
    end else if (active_q) begin
      if (tick) begin
        cnt_q <= '0;
        if (!half_q) begin
          half_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso};
        end else if (bit_q == 3'd0) begin
          active_q <= 1'b0;
          half_q   <= 1'b0;
        end else begin
          half_q <= 1'b0;
          bit_q  <= bit_q - 3'd1;
          sh_q   <= {sh_q[6:0], 1'b0};
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o  = active_q;
  assign rx_byte_o = rx_q;
  assign sclk_o    = active_q ? half_q : cfg_cpol;
  assign mosi_o    = sh_q[7];
endmodule

// File: rtl/spi_desel_timer.sv
`timescale 1ns/1ps
// Counts the chip-select high time; last_o marks the final counted cycle.
module spi_desel_timer #(
  parameter int DSL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DSL_W-1:0] load_val,
  output logic             last_o
);
  logic [DSL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? DSL_W'(1) : load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == DSL_W'(1));
endmodule

// File: rtl/spi_txn_seq.sv
`timescale 1ns/1ps
module spi_txn_seq
  import spi_seq_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DSL_W   = 16,
  parameter int LEN_W   = 16,
  parameter int CMD_MAX = 5,
  localparam int CMD_W  = 8 * CMD_MAX,
  localparam int CLEN_W = $clog2(CMD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DSL_W-1:0]  cfg_desel_rd,
  input  logic [DSL_W-1:0]  cfg_desel_pgm,
  input  logic [DSL_W-1:0]  cfg_desel_oth,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [CLEN_W-1:0] req_cmd_len,
  input  logic [LEN_W-1:0]  req_data_len,
  input  logic              req_read,
  input  logic [1:0]        req_class,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_hold_n,
  input  logic              spi_miso
);
  seq_state_e        state_q;
  logic [CMD_W-1:0]  cmd_sh_q;
  logic [CLEN_W-1:0] cmd_left_q;
  logic [LEN_W-1:0]  data_left_q;
  logic              dir_rd_q;
  txn_class_e        cls_q;
  logic              cs_n_q;
  logic              hold_q;
  logic [7:0]        rd_data_q;
  logic              rd_valid_q;

  logic              eng_active;
  logic              eng_done;
  logic              eng_start;
  logic [7:0]        eng_tx;
  logic [7:0]        eng_rx;
  logic              gap_last;
  logic              gap_load;
  logic [DSL_W-1:0]  gap_val;
  logic              accept;
  logic              finish;

  function automatic logic [CLEN_W-1:0] clamp_len(input logic [CLEN_W-1:0] l);
    if (l == '0) return CLEN_W'(1);
    if (l > CLEN_W'(CMD_MAX)) return CLEN_W'(CMD_MAX);
    return l;
  endfunction

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign wr_ready  = (state_q == ST_DATA) && !dir_rd_q && !eng_active;

  assign eng_start = !eng_active &&
                     ((state_q == ST_CMD) ||
                      ((state_q == ST_DATA) && (dir_rd_q ? !rd_valid_q : wr_valid)));
  assign eng_tx    = (state_q == ST_CMD) ? cmd_sh_q[CMD_W-1 -: 8] :
                     (dir_rd_q ? 8'h00 : wr_data);

  // Last byte of the transaction completes on this edge.
  assign finish = eng_done &&
                  (((state_q == ST_CMD) && (cmd_left_q == CLEN_W'(1)) && (data_left_q == '0)) ||
                   ((state_q == ST_DATA) && (data_left_q == LEN_W'(1))));
  assign gap_load = finish;

  always_comb begin
    unique case (cls_q)
      CLS_READ: gap_val = cfg_desel_rd;
      CLS_PROG: gap_val = cfg_desel_pgm;
      default:  gap_val = cfg_desel_oth;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cmd_sh_q    <= '0;
      cmd_left_q  <= '0;
      data_left_q <= '0;
      dir_rd_q    <= 1'b0;
      cls_q       <= CLS_OTHER;
      cs_n_q      <= 1'b1;
      hold_q      <= 1'b0;
      rd_data_q   <= 8'h00;
      rd_valid_q  <= 1'b0;
    end else begin
      if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cmd_sh_q    <= req_cmd;
          cmd_left_q  <= clamp_len(req_cmd_len);
          data_left_q <= req_data_len;
          dir_rd_q    <= req_read;
          cls_q       <= txn_class_e'(req_class);
          cs_n_q      <= 1'b0;
          hold_q      <= 1'b1;
          state_q     <= ST_CMD;
        end
        ST_CMD: if (eng_done) begin
          cmd_sh_q   <= {cmd_sh_q[CMD_W-9:0], 8'h00};
          cmd_left_q <= cmd_left_q - 1'b1;
          if (finish) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_GAP;
          end else if (cmd_left_q == CLEN_W'(1)) begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (eng_done) begin
          data_left_q <= data_left_q - 1'b1;
          if (dir_rd_q) begin
            rd_data_q  <= eng_rx;
            rd_valid_q <= 1'b1;
          end
          if (finish) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (gap_last) begin
          hold_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_div   (cfg_div),
    .cfg_cpol  (cfg_cpol),
    .start     (eng_start),
    .tx_byte   (eng_tx),
    .miso      (spi_miso),
    .active_o  (eng_active),
    .done_o    (eng_done),
    .rx_byte_o (eng_rx),
    .sclk_o    (spi_sclk),
    .mosi_o    (spi_mosi)
  );

  spi_desel_timer #(.DSL_W(DSL_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .last_o   (gap_last)
  );

  assign spi_cs_n   = cs_n_q;
  assign spi_hold_n = hold_q;
  assign rd_data    = rd_data_q;
  assign rd_valid   = rd_valid_q;
endmodule

// File: rtl/spi_txn_seq_chk.sv
`timescale 1ns/1ps
module spi_txn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cpol,
  input logic       req_ready,
  input logic       busy,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_hold_n
);
  p_hold_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> spi_hold_n);

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (spi_sclk == cfg_cpol));

  p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk && $past(spi_sclk) && !$past(spi_cs_n)) |-> $stable(spi_mosi));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  p_cs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_wr_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n);
endmodule

bind spi_txn_seq spi_txn_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_cpol   (cfg_cpol),
  .req_ready  (req_ready),
  .busy       (busy),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .spi_cs_n   (spi_cs_n),
  .spi_sclk   (spi_sclk),
  .spi_mosi   (spi_mosi),
  .spi_hold_n (spi_hold_n)
);

// File: tb/spi_txn_seq_tb.sv
`timescale 1ns/1ps
module spi_txn_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cpol = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [15:0] cfg_desel_rd = 16'd3, cfg_desel_pgm = 16'd7, cfg_desel_oth = 16'd0;
  logic        req_valid = 1'b0, req_ready;
  logic [39:0] req_cmd = '0;
  logic [2:0]  req_cmd_len = 3'd1;
  logic [15:0] req_data_len = '0;
  logic        req_read = 1'b0;
  logic [1:0]  req_class = 2'd0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        busy, spi_cs_n, spi_sclk, spi_mosi, spi_hold_n;
  logic        spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_txn_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_div(cfg_div),
    .cfg_desel_rd(cfg_desel_rd), .cfg_desel_pgm(cfg_desel_pgm), .cfg_desel_oth(cfg_desel_oth),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_cmd_len(req_cmd_len), .req_data_len(req_data_len), .req_read(req_read),
    .req_class(req_class), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_hold_n(spi_hold_n), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // Serial slave model and cycle counters
  int          rise_cnt = 0;
  int          cur_clen = 1;
  int          txn_id = 0;
  int          lo_cnt = 0;
  int          hi_cnt = 0;
  int          last_gap = 0;
  logic [7:0]  cur_mosi = 8'h00;
  logic [7:0]  mosi_bytes[$];

  function automatic logic [7:0] rd_pat(input int t, input int i);
    return 8'(t * 29 + i * 13 + 90);
  endfunction
  function automatic logic [7:0] wr_pat(input int t, input int i);
    return 8'(t * 7 + i * 31 + 1);
  endfunction
  function automatic int gap_exp(input logic [1:0] cls);
    int t;
    t = (cls == 2'd1) ? int'(cfg_desel_rd) : (cls == 2'd2) ? int'(cfg_desel_pgm) : int'(cfg_desel_oth);
    return ((t < 1) ? 1 : t) + 1;
  endfunction

  always @(posedge spi_sclk) begin
    if (spi_cs_n === 1'b0) begin
      cur_mosi = {cur_mosi[6:0], spi_mosi};
      rise_cnt++;
      if (rise_cnt % 8 == 0) mosi_bytes.push_back(cur_mosi);
    end
  end

  always @(negedge clk) begin
    logic [7:0] b;
    int k;
    k = rise_cnt / 8;
    b = (k < cur_clen) ? 8'(8'h3C ^ k) : rd_pat(txn_id, k - cur_clen);
    spi_miso = b[7 - (rise_cnt % 8)];
    if (rst_n) begin
      if (spi_cs_n === 1'b1) hi_cnt++;
      else if (spi_cs_n === 1'b0) begin
        lo_cnt++;
        if (hi_cnt > 0) begin
          last_gap = hi_cnt;
          hi_cnt = 0;
        end
      end
    end
  end

  task automatic run_txn(input logic [39:0] cmd, input int clen, input int dlen,
                         input bit rd, input logic [1:0] cls, input int stall);
    logic [7:0] got[$];
    logic [7:0] exp_b;
    rise_cnt = 0;
    lo_cnt = 0;
    mosi_bytes.delete();
    cur_clen = clen;
    txn_id++;
    req_cmd = cmd;
    req_cmd_len = 3'(clen);
    req_data_len = 16'(dlen);
    req_read = rd;
    req_class = cls;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "req_ready during transaction", req_ready, 0);
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
    chk(spi_hold_n == 1'b1, "R9", "hold_n while selected", spi_hold_n, 1);
    fork
      begin
        if (rd) begin
          for (int i = 0; i < dlen; i++) begin
            rd_ready = 1'b0;
            repeat ($urandom_range(0, stall)) @(negedge clk);
            rd_ready = 1'b1;
            while (!rd_valid) @(negedge clk);
            got.push_back(rd_data);
            @(negedge clk);
          end
          rd_ready = 1'b0;
        end else begin
          for (int i = 0; i < dlen; i++) begin
            wr_valid = 1'b0;
            repeat ($urandom_range(0, stall)) @(negedge clk);
            wr_valid = 1'b1;
            wr_data = wr_pat(txn_id, i);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
          end
          wr_valid = 1'b0;
        end
      end
      begin
        while (!spi_cs_n) @(negedge clk);
      end
    join
    // R3 / R6: rising edge count per transaction
    chk(rise_cnt == 8 * (clen + dlen), (dlen == 0) ? "R6" : "R3", "SCLK rising edges",
        rise_cnt, 8 * (clen + dlen));
    for (int i = 0; i < clen; i++) begin
      exp_b = 8'(cmd >> (32 - 8 * i));
      chk(i < mosi_bytes.size() && mosi_bytes[i] == exp_b, "R2", "command byte",
          (i < mosi_bytes.size()) ? mosi_bytes[i] : 'hx, exp_b);
    end
    if (rd) begin
      for (int i = 0; i < dlen; i++)
        chk(i < got.size() && got[i] == rd_pat(txn_id, i), "R5", "read byte",
            (i < got.size()) ? got[i] : 'hx, rd_pat(txn_id, i));
    end else begin
      for (int i = 0; i < dlen; i++)
        chk(clen + i < mosi_bytes.size() && mosi_bytes[clen + i] == wr_pat(txn_id, i), "R4",
            "write byte", (clen + i < mosi_bytes.size()) ? mosi_bytes[clen + i] : 'hx,
            wr_pat(txn_id, i));
      if (stall == 0)
        chk(lo_cnt == (clen + dlen) * (16 * (int'(cfg_div) + 1) + 1), "R7", "CS low cycles",
            lo_cnt, (clen + dlen) * (16 * (int'(cfg_div) + 1) + 1));
    end
    chk(spi_sclk == cfg_cpol, "R7", "SCLK idle level after release", spi_sclk, cfg_cpol);
  endtask

  initial begin
    #(5ns * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    int unsigned seed_v;
    logic [1:0] prev_cls;
    seed_v = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && busy == 1'b0, "R1", "cs_n/busy after reset", {spi_cs_n, busy}, 2'b10);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rd_valid == 1'b0 && wr_ready == 1'b0, "R1", "rd_valid/wr_ready after reset",
        {rd_valid, wr_ready}, 0);
    chk(spi_sclk == 1'b0, "R1", "SCLK idle after reset", spi_sclk, 0);

    // Directed: command only (R6), mode 0
    run_txn(40'h9F_00_00_00_00, 1, 0, 1'b0, 2'd0, 0);
    // Program-class write followed at once by another request (R8)
    run_txn(40'h02_00_12_34_00, 4, 3, 1'b0, 2'd2, 0);
    run_txn(40'h06_00_00_00_00, 1, 0, 1'b0, 2'd0, 0);
    chk(last_gap == gap_exp(2'd2), "R8", "deselect gap after program class", last_gap, gap_exp(2'd2));
    // Mode 3 read with full 5-byte command (R5, R7)
    cfg_cpol = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_sclk == 1'b1, "R7", "mode 3 idle level", spi_sclk, 1);
    run_txn(40'h0B_00_00_10_00, 5, 4, 1'b1, 2'd1, 0);
    run_txn(40'h05_00_00_00_00, 1, 2, 1'b0, 2'd3, 0);
    chk(last_gap == gap_exp(2'd1), "R8", "deselect gap after read class", last_gap, gap_exp(2'd1));
    run_txn(40'hAB_00_00_00_00, 2, 1, 1'b0, 2'd0, 0);
    chk(last_gap == gap_exp(2'd3), "R8", "deselect gap after other class (zero)", last_gap, gap_exp(2'd3));
    // Stalled streams (R4, R5)
    cfg_cpol = 1'b0;
    cfg_div = 8'd2;
    run_txn(40'h32_01_02_03_00, 4, 5, 1'b0, 2'd2, 6);
    run_txn(40'h03_0A_0B_0C_00, 4, 5, 1'b1, 2'd1, 6);

    // Constrained random transactions
    prev_cls = 2'd1;
    for (int n = 0; n < 40; n++) begin
      logic [39:0] c;
      int cl, dl, st;
      bit r;
      logic [1:0] cs;
      c  = {$urandom, 8'($urandom)};
      cl = $urandom_range(1, 5);
      dl = $urandom_range(0, 6);
      r  = 1'($urandom_range(0, 1));
      cs = 2'($urandom_range(0, 3));
      st = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 4);
      cfg_div = 8'($urandom_range(0, 3));
      cfg_cpol = 1'($urandom_range(0, 1));
      run_txn(c, cl, dl, r, cs, st);
      chk(last_gap >= gap_exp(prev_cls), "R8", "minimum deselect gap", last_gap, gap_exp(prev_cls));
      prev_cls = cs;
    end

    report();
    $finish;
  end
endmodule